// File: doc/BRIEF.md
# Multi-Page Access Checker with Low-Address Protection

This block validates a memory access before any data is moved. Given a logical start address, a byte length and a read/write flag, it works out how many 4 KB pages the access touches. It then walks those pages from lowest to highest. For each page it asks an external translator for the absolute frame, and the translator also reports whether that frame lies in valid memory. The absolute addresses are collected into a small indexed list. The first problem ends the walk, and one status code is reported.

On writes, the block can refuse the access on its own when low-address protection is active. Protection is active when the control-register-0 enable bit is set and one of two conditions holds:
- address translation is off, or
- translation is on and the descriptor picked by the current address-space selector does not mark its space as private.

Two 512-byte windows are guarded: one at address zero and one at the start of the second 4 KB page. The surrounding logic pulses `start`, waits for `done`, and on an OK status reads the page list through `rd_idx`.

Top module: `mpc_access_checker`

## Requirements
- R1: After reset, `busy`, `done` and `tr_req_valid` are low, `status` is OK (0) and `pages_done` is 0.
- R2: The page count is ((start_addr mod 4096) + length - 1) / 4096 + 1, and a length of 0 gives zero pages with status OK. A count above MAX_PAGES (default 8) ends with status TOO_LONG (5), and no translation request is issued.
- R3: The translation request for page i carries start_addr + 4096*i, and i runs in ascending order. After an OK end, list entry i (read via `rd_idx`) holds the absolute address returned for page i, and `pages_done` equals the page count.
- R4: Low-address protection is inactive when `lap_en` is 0. When `lap_en` is 1 and `dat_on` is 0, it is active whatever the selector and private bits are.
- R5: With `dat_on` = 1, protection is active unless the private bit of the selected descriptor is set. `space_sel` 00 selects `priv_primary`, 10 selects `priv_secondary` and 11 selects `priv_home`.
- R6: Protection acts only on writes. A page address in 0..511 or 4096..4607 ends the walk before that page is requested, with status PROT (1) and `fault_code` 0. Reads and addresses outside the windows are unaffected.
- R7: A response with `tr_rsp_fault` set ends the walk with status XLATE (2), and `fault_code` equals the response's code. No further page is requested.
- R8: A non-faulting response with `tr_rsp_in_range` low ends the walk with status ADDRESSING (3). No further page is requested, and the page is not counted.
- R9: With `dat_on` = 1 and `space_sel` = 01, the access ends with status MODE (4) and no request. With `dat_on` = 0 the selector is not checked.
- R10: `done` is a one-cycle pulse that ends each access. `busy` is high from the cycle after `start` until `done`. `start` is ignored while busy.
- R11: `tr_req_valid` stays high with a stable `tr_req_addr` until a cycle in which `tr_rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access (sampled when idle) |
| start_addr | input | ADDR_W | Logical start address |
| length | input | LEN_W | Access length in bytes |
| is_write | input | 1 | 1 = store access |
| space_sel | input | 2 | Address-space selector: 00 primary, 01 access-register, 10 secondary, 11 home |
| dat_on | input | 1 | Address translation enabled |
| lap_en | input | 1 | Low-address-protection enable bit from control register 0 |
| priv_primary | input | 1 | Private-space bit of the primary descriptor (control register 1) |
| priv_secondary | input | 1 | Private-space bit of the secondary descriptor (control register 7) |
| priv_home | input | 1 | Private-space bit of the home descriptor (control register 13) |
| tr_req_valid | output | 1 | Translation request pending |
| tr_req_addr | output | ADDR_W | Logical address of the page being translated |
| tr_rsp_valid | input | 1 | Translation response present |
| tr_rsp_fault | input | 1 | Translation failed |
| tr_rsp_code | input | CODE_W | Exception code of a failed translation |
| tr_rsp_abs | input | ADDR_W | Absolute page address |
| tr_rsp_in_range | input | 1 | Absolute address lies in valid memory |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| status | output | 3 | Result: 0 OK, 1 PROT, 2 XLATE, 3 ADDRESSING, 4 MODE, 5 TOO_LONG |
| fault_code | output | CODE_W | Translator code on XLATE, else 0 |
| pages_done | output | LEN_W+1 | Pages translated successfully |
| rd_idx | input | IDX_W | Page-list read index |
| rd_abs | output | ADDR_W | Page-list entry at `rd_idx` |

## Verification
The timing runs as follows:
- `start` is taken at one rising edge, and the first check cycle follows at the next edge.
- Each page costs one check cycle plus at least one request cycle.
- `done` rises at the edge that makes the final decision. `status`, `fault_code` and `pages_done` then hold until the next `start`.

The bench's translator model answers on a falling edge, either at once or after a chosen delay, and logs each request address in arrival order. Every result is read on the falling edge where `done` is first seen high. One falling edge later, the bench confirms that `done` has dropped again. The list entries are read back through `rd_idx` in that same low phase, before any new stimulus.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [2:0] {
      ST_OK    = 3'd0,
      ST_PROT  = 3'd1,
      ST_XLATE = 3'd2,
      ST_ADDR  = 3'd3,
      ST_MODE  = 3'd4,
      ST_LONG  = 3'd5
   } acc_status_e;

   typedef enum logic [1:0] {
      SP_PRIMARY   = 2'b00,
      SP_ACCREG    = 2'b01,
      SP_SECONDARY = 2'b10,
      SP_HOME      = 2'b11
   } space_e;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_CHECK,
      FS_REQ
   } walk_state_e;
endpackage

// File: rtl/mpc_lap_decide.sv
module mpc_lap_decide
   import mpc_pkg::*;
(
   input  logic       lap_en,
   input  logic       dat_on,
   input  logic [1:0] space_sel,
   input  logic       priv_primary,
   input  logic       priv_secondary,
   input  logic       priv_home,
   output logic       lap_on
);
   logic priv_sel;

   always_comb begin
      unique case (space_e'(space_sel))
         SP_PRIMARY:   priv_sel = priv_primary;
         SP_SECONDARY: priv_sel = priv_secondary;
         SP_HOME:      priv_sel = priv_home;
         default:      priv_sel = 1'b1;
      endcase
   end

   assign lap_on = lap_en && (!dat_on || !priv_sel);
endmodule

// File: rtl/mpc_span_calc.sv
module mpc_span_calc #(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 16,
   parameter int PAGE_SHIFT = 12,
   localparam int NP_W      = LEN_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic [NP_W-1:0]   npages
);
   logic [NP_W-1:0] last_byte;

   assign last_byte = NP_W'(addr[PAGE_SHIFT-1:0]) + NP_W'(len) - NP_W'(1);
   assign npages    = (len == '0) ? '0 : (last_byte >> PAGE_SHIFT) + NP_W'(1);
endmodule

// File: rtl/mpc_page_buf.sv
module mpc_page_buf #(
   parameter int DEPTH   = 8,
   parameter int DATA_W  = 64,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            slot[g] <= wr_data;
      end
   end

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mpc_access_checker.sv
module mpc_access_checker
   import mpc_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 16,
   parameter int CODE_W     = 8,
   parameter int MAX_PAGES  = 8,
   parameter int PAGE_SHIFT = 12,
   parameter int LOW_WIN    = 512,
   localparam int IDX_W     = $clog2(MAX_PAGES),
   localparam int NP_W      = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  length,
   input  logic              is_write,
   input  logic [1:0]        space_sel,
   input  logic              dat_on,
   input  logic              lap_en,
   input  logic              priv_primary,
   input  logic              priv_secondary,
   input  logic              priv_home,
   output logic              tr_req_valid,
   output logic [ADDR_W-1:0] tr_req_addr,
   input  logic              tr_rsp_valid,
   input  logic              tr_rsp_fault,
   input  logic [CODE_W-1:0] tr_rsp_code,
   input  logic [ADDR_W-1:0] tr_rsp_abs,
   input  logic              tr_rsp_in_range,
   output logic              busy,
   output logic              done,
   output logic [2:0]        status,
   output logic [CODE_W-1:0] fault_code,
   output logic [NP_W-1:0]   pages_done,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_abs
);
   localparam logic [ADDR_W-1:0] PAGE_SZ = ADDR_W'(1) << PAGE_SHIFT;
   localparam logic [ADDR_W-1:0] WIN_SZ  = ADDR_W'(LOW_WIN);

   if (LEN_W < PAGE_SHIFT) begin : g_chk_len
      $error("LEN_W must be at least PAGE_SHIFT");
   end
   if (MAX_PAGES < 2 || (1 << IDX_W) != MAX_PAGES) begin : g_chk_depth
      $error("MAX_PAGES must be a power of two of at least 2");
   end
   if (LOW_WIN < 1 || LOW_WIN > (1 << PAGE_SHIFT)) begin : g_chk_win
      $error("LOW_WIN must fit inside one page");
   end

   walk_state_e       state;
   logic [ADDR_W-1:0] cur_q;
   logic [NP_W-1:0]   np_q, idx_q, np_calc;
   logic              wr_q, lap_q, bad_q, lap_calc;
   logic              done_q;
   acc_status_e       status_q;
   logic [CODE_W-1:0] code_q;

   logic              fin_now, go_req, adv, in_win;
   acc_status_e       fin_st;

   mpc_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_span (
      .addr   (start_addr),
      .len    (length),
      .npages (np_calc)
   );

   mpc_lap_decide u_lap (
      .lap_en         (lap_en),
      .dat_on         (dat_on),
      .space_sel      (space_sel),
      .priv_primary   (priv_primary),
      .priv_secondary (priv_secondary),
      .priv_home      (priv_home),
      .lap_on         (lap_calc)
   );

   mpc_page_buf #(.DEPTH(MAX_PAGES), .DATA_W(ADDR_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (adv),
      .wr_idx  (idx_q[IDX_W-1:0]),
      .wr_data (tr_rsp_abs),
      .rd_idx  (rd_idx),
      .rd_data (rd_abs)
   );

   assign in_win = (cur_q < WIN_SZ) ||
                   ((cur_q >= PAGE_SZ) && (cur_q < PAGE_SZ + WIN_SZ));

   always_comb begin
      fin_now = 1'b0;
      fin_st  = ST_OK;
      go_req  = 1'b0;
      adv     = 1'b0;
      unique case (state)
         FS_CHECK: begin
            if (bad_q) begin
               fin_now = 1'b1;
               fin_st  = ST_MODE;
            end else if (np_q > NP_W'(MAX_PAGES)) begin
               fin_now = 1'b1;
               fin_st  = ST_LONG;
            end else if (idx_q == np_q) begin
               fin_now = 1'b1;
               fin_st  = ST_OK;
            end else if (wr_q && lap_q && in_win) begin
               fin_now = 1'b1;
               fin_st  = ST_PROT;
            end else begin
               go_req  = 1'b1;
            end
         end
         FS_REQ: begin
            if (tr_rsp_valid) begin
               if (tr_rsp_fault) begin
                  fin_now = 1'b1;
                  fin_st  = ST_XLATE;
               end else if (!tr_rsp_in_range) begin
                  fin_now = 1'b1;
                  fin_st  = ST_ADDR;
               end else begin
                  adv     = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_IDLE;
         cur_q    <= '0;
         np_q     <= '0;
         idx_q    <= '0;
         wr_q     <= 1'b0;
         lap_q    <= 1'b0;
         bad_q    <= 1'b0;
         done_q   <= 1'b0;
         status_q <= ST_OK;
         code_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (state == FS_IDLE) begin
            if (start) begin
               cur_q <= start_addr;
               np_q  <= np_calc;
               idx_q <= '0;
               wr_q  <= is_write;
               lap_q <= lap_calc;
               bad_q <= dat_on && (space_e'(space_sel) == SP_ACCREG);
               state <= FS_CHECK;
            end
         end else if (fin_now) begin
            done_q   <= 1'b1;
            status_q <= fin_st;
            code_q   <= (fin_st == ST_XLATE) ? tr_rsp_code : '0;
            state    <= FS_IDLE;
         end else if (go_req) begin
            state <= FS_REQ;
         end else if (adv) begin
            cur_q <= cur_q + PAGE_SZ;
            idx_q <= idx_q + NP_W'(1);
            state <= FS_CHECK;
         end
      end
   end

   assign tr_req_valid = (state == FS_REQ);
   assign tr_req_addr  = cur_q;
   assign busy         = (state != FS_IDLE);
   assign done         = done_q;
   assign status       = status_q;
   assign fault_code   = code_q;
   assign pages_done   = idx_q;
endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
   import mpc_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 16,
   parameter int CODE_W     = 8,
   parameter int MAX_PAGES  = 8,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tr_req_valid,
   input logic [ADDR_W-1:0] tr_req_addr,
   input logic              tr_rsp_valid,
   input logic              tr_rsp_fault,
   input logic              tr_rsp_in_range,
   input logic              busy,
   input logic              done,
   input logic [2:0]        status,
   input logic [CODE_W-1:0] fault_code,
   input logic [LEN_W:0]    pages_done
);
   localparam logic [ADDR_W-1:0] PAGE_SZ = ADDR_W'(1) << PAGE_SHIFT;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tr_req_valid && !tr_rsp_valid |=> tr_req_valid && $stable(tr_req_addr)); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tr_req_valid); // R10
   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tr_req_valid && tr_rsp_valid && !tr_rsp_fault && tr_rsp_in_range
      |=> tr_req_addr == $past(tr_req_addr) + PAGE_SZ); // R3
   AST_PROT_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done && status == ST_PROT |-> fault_code == '0); // R6
   AST_PAGES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pages_done <= (LEN_W+1)'(MAX_PAGES)); // R2
   AST_MODE_NO_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
      done && status == ST_MODE |-> pages_done == '0); // R9
endmodule

bind mpc_access_checker mpc_checker #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CODE_W(CODE_W),
   .MAX_PAGES(MAX_PAGES), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .tr_req_valid    (tr_req_valid),
   .tr_req_addr     (tr_req_addr),
   .tr_rsp_valid    (tr_rsp_valid),
   .tr_rsp_fault    (tr_rsp_fault),
   .tr_rsp_in_range (tr_rsp_in_range),
   .busy            (busy),
   .done            (done),
   .status          (status),
   .fault_code      (fault_code),
   .pages_done      (pages_done)
);

// File: tb/mpc_access_checker_tb.sv
`timescale 1ns/1ps
module mpc_access_checker_tb;
   localparam int ADDR_W = 64;
   localparam int LEN_W  = 16;
   localparam int CODE_W = 8;
   localparam int MAXP   = 8;
   localparam int IDX_W  = 3;
   localparam int NP_W   = LEN_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              start = 0, is_write = 0, dat_on = 0, lap_en = 0;
   logic              priv_primary = 0, priv_secondary = 0, priv_home = 0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [LEN_W-1:0]  length = '0;
   logic [1:0]        space_sel = 2'b00;
   logic              tr_req_valid;
   logic [ADDR_W-1:0] tr_req_addr;
   logic              tr_rsp_valid = 0, tr_rsp_fault = 0, tr_rsp_in_range = 1;
   logic [CODE_W-1:0] tr_rsp_code = '0;
   logic [ADDR_W-1:0] tr_rsp_abs = '0;
   logic              busy, done;
   logic [2:0]        status;
   logic [CODE_W-1:0] fault_code;
   logic [NP_W-1:0]   pages_done;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic [ADDR_W-1:0] rd_abs;

   mpc_access_checker u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .length(length), .is_write(is_write), .space_sel(space_sel),
      .dat_on(dat_on), .lap_en(lap_en), .priv_primary(priv_primary),
      .priv_secondary(priv_secondary), .priv_home(priv_home),
      .tr_req_valid(tr_req_valid), .tr_req_addr(tr_req_addr),
      .tr_rsp_valid(tr_rsp_valid), .tr_rsp_fault(tr_rsp_fault),
      .tr_rsp_code(tr_rsp_code), .tr_rsp_abs(tr_rsp_abs),
      .tr_rsp_in_range(tr_rsp_in_range), .busy(busy), .done(done),
      .status(status), .fault_code(fault_code), .pages_done(pages_done),
      .rd_idx(rd_idx), .rd_abs(rd_abs)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // translator model settings, written only by the scenario tasks
   int                fault_at  = -1;
   int                range_at  = -1;
   int                rsp_delay = 0;
   logic [ADDR_W-1:0] base_addr = '0;

   // translator model state, written only by the responder
   int                req_cnt   = 0;
   int                wait_cnt  = 0;
   logic              hold_bad  = 1'b0;
   logic [ADDR_W-1:0] first_addr = '0;
   logic [ADDR_W-1:0] req_log [32];

   function automatic logic [ADDR_W-1:0] frame_of(input logic [ADDR_W-1:0] a);
      return {a[ADDR_W-1:12] + 52'h100, 12'h000};
   endfunction

   always @(negedge clk) begin
      if (tr_rsp_valid) begin
         tr_rsp_valid <= 1'b0;
         wait_cnt     <= 0;
      end else if (tr_req_valid) begin
         if (wait_cnt == 0)
            first_addr <= tr_req_addr;
         else if (tr_req_addr != first_addr)
            hold_bad <= 1'b1; // R11
         if (wait_cnt >= rsp_delay) begin
            automatic int seq = int'((tr_req_addr - base_addr) >> 12);
            tr_rsp_valid    <= 1'b1;
            tr_rsp_fault    <= (seq == fault_at);
            tr_rsp_in_range <= (seq != range_at);
            tr_rsp_code     <= CODE_W'(8'h40 + seq);
            tr_rsp_abs      <= frame_of(tr_req_addr);
            req_log[req_cnt % 32] <= tr_req_addr;
            req_cnt         <= req_cnt + 1;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // drive one access and wait for its done pulse; returns request count snapshot
   task automatic run(input logic [ADDR_W-1:0] a, input int len, input bit wr,
                      input logic [1:0] sp, input bit dat, input bit lap,
                      input bit pp, input bit ps, input bit ph, output int c0);
      @(negedge clk);
      base_addr = a; start_addr = a; length = LEN_W'(len); is_write = wr;
      space_sel = sp; dat_on = dat; lap_en = lap;
      priv_primary = pp; priv_secondary = ps; priv_home = ph;
      c0 = req_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (done) break;
         @(negedge clk);
      end
      chk(done === 1'b1, "R10 done seen", longint'(done), 1);
   endtask

   task automatic expect_res(input string tag, input int c0, input int st,
                             input int np, input int nreq, input int code);
      chk(status == 3'(st), {tag, " status"}, longint'(status), st);
      chk(pages_done == NP_W'(np), {tag, " pages_done"}, longint'(pages_done), np);
      chk(req_cnt - c0 == nreq, {tag, " request count"}, req_cnt - c0, nreq);
      chk(fault_code == CODE_W'(code), {tag, " fault_code"}, longint'(fault_code), code);
      for (int i = 0; i < nreq; i++)
         chk(req_log[(c0 + i) % 32] == base_addr + ADDR_W'(i) * 4096, {tag, " R3 request order"},
             longint'(req_log[(c0 + i) % 32]), longint'(base_addr + ADDR_W'(i) * 4096));
      for (int i = 0; i < np; i++) begin
         rd_idx = IDX_W'(i);
         #0.2;
         chk(rd_abs == frame_of(base_addr + ADDR_W'(i) * 4096), {tag, " R3 list entry"},
             longint'(rd_abs), longint'(frame_of(base_addr + ADDR_W'(i) * 4096)));
      end
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, {tag, " R10 done single pulse"}, longint'({busy, done}), 0);
   endtask

   task automatic t_reset();
      chk(busy == 0 && done == 0 && tr_req_valid == 0, "R1 control outputs low",
          longint'({busy, done, tr_req_valid}), 0);
      chk(status == 3'd0 && pages_done == '0, "R1 status and count", longint'(status), 0);
   endtask

   task automatic t_spans();
      int c0;
      run(64'h12340, 100, 0, 2'b00, 1, 0, 0, 0, 0, c0);   expect_res("R2 single page", c0, 0, 1, 1, 0);
      run(64'h12FF0, 32, 0, 2'b00, 1, 0, 0, 0, 0, c0);    expect_res("R2 crossing", c0, 0, 2, 2, 0);
      run(64'h20800, 12288, 0, 2'b00, 1, 0, 0, 0, 0, c0); expect_res("R2 four pages", c0, 0, 4, 4, 0);
      run(64'h30000, 4096, 0, 2'b00, 1, 0, 0, 0, 0, c0);  expect_res("R2 exact page", c0, 0, 1, 1, 0);
      run(64'h30000, 4097, 1, 2'b00, 1, 0, 0, 0, 0, c0);  expect_res("R2 one byte over", c0, 0, 2, 2, 0);
      run(64'h40000, 32768, 0, 2'b10, 1, 0, 0, 0, 0, c0); expect_res("R2 full list", c0, 0, 8, 8, 0);
      run(64'h40000, 32769, 0, 2'b00, 1, 0, 0, 0, 0, c0); expect_res("R2 too long", c0, 5, 0, 0, 0);
      run(64'h40000, 0, 1, 2'b00, 0, 1, 0, 0, 0, c0);     expect_res("R2 zero length", c0, 0, 0, 0, 0);
   endtask

   task automatic t_lap_sources();
      int c0;
      run(64'h100, 8, 1, 2'b00, 0, 1, 1, 1, 1, c0); expect_res("R4 real mode on", c0, 1, 0, 0, 0);
      run(64'h100, 8, 1, 2'b00, 0, 0, 0, 0, 0, c0); expect_res("R4 enable clear", c0, 0, 1, 1, 0);
      run(64'h100, 8, 1, 2'b00, 1, 1, 1, 0, 0, c0); expect_res("R5 primary private", c0, 0, 1, 1, 0);
      run(64'h100, 8, 1, 2'b00, 1, 1, 0, 1, 1, c0); expect_res("R5 primary shared", c0, 1, 0, 0, 0);
      run(64'h100, 8, 1, 2'b10, 1, 1, 0, 1, 0, c0); expect_res("R5 secondary private", c0, 0, 1, 1, 0);
      run(64'h100, 8, 1, 2'b10, 1, 1, 1, 0, 1, c0); expect_res("R5 secondary shared", c0, 1, 0, 0, 0);
      run(64'h100, 8, 1, 2'b11, 1, 1, 0, 0, 1, c0); expect_res("R5 home private", c0, 0, 1, 1, 0);
      run(64'h100, 8, 1, 2'b11, 1, 1, 1, 1, 0, c0); expect_res("R5 home shared", c0, 1, 0, 0, 0);
   endtask

   task automatic t_windows();
      int c0;
      run(64'h100, 8, 0, 2'b00, 0, 1, 0, 0, 0, c0);  expect_res("R6 read ignored", c0, 0, 1, 1, 0);
      run(64'h1FF, 1, 1, 2'b00, 0, 1, 0, 0, 0, c0);  expect_res("R6 last low byte", c0, 1, 0, 0, 0);
      run(64'h200, 1, 1, 2'b00, 0, 1, 0, 0, 0, c0);  expect_res("R6 above low window", c0, 0, 1, 1, 0);
      run(64'h1000, 1, 1, 2'b00, 0, 1, 0, 0, 0, c0); expect_res("R6 second window start", c0, 1, 0, 0, 0);
      run(64'h11FF, 1, 1, 2'b00, 0, 1, 0, 0, 0, c0); expect_res("R6 second window end", c0, 1, 0, 0, 0);
      run(64'h1200, 1, 1, 2'b00, 0, 1, 0, 0, 0, c0); expect_res("R6 past second window", c0, 0, 1, 1, 0);
      run(64'hFFF, 2, 1, 2'b00, 0, 1, 0, 0, 0, c0);  expect_res("R6 straddle unhit", c0, 0, 2, 2, 0);
   endtask

   task automatic t_faults();
      int c0;
      fault_at = 1;
      run(64'h50000, 12288, 0, 2'b00, 1, 0, 0, 0, 0, c0); expect_res("R7 fault page 1", c0, 2, 1, 2, 8'h41);
      fault_at = 0;
      run(64'h50010, 16, 1, 2'b00, 1, 0, 0, 0, 0, c0);    expect_res("R7 fault page 0", c0, 2, 0, 1, 8'h40);
      fault_at = -1; range_at = 2;
      run(64'h60000, 12288, 0, 2'b00, 1, 0, 0, 0, 0, c0); expect_res("R8 out of range", c0, 3, 2, 3, 0);
      range_at = -1;
   endtask

   task automatic t_mode_and_hold();
      int c0;
      run(64'h70000, 64, 0, 2'b01, 1, 0, 0, 0, 0, c0);  expect_res("R9 access-register mode", c0, 4, 0, 0, 0);
      run(64'h70000, 64, 0, 2'b01, 0, 0, 0, 0, 0, c0);  expect_res("R9 ignored without DAT", c0, 0, 1, 1, 0);
      rsp_delay = 3;
      run(64'h80000, 8192, 1, 2'b00, 1, 0, 0, 0, 0, c0); expect_res("R11 slow translator", c0, 0, 2, 2, 0);
      rsp_delay = 0;
      chk(hold_bad == 1'b0, "R11 request held stable", longint'(hold_bad), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_spans();
      t_lap_sources();
      t_windows();
      t_faults();
      t_mode_and_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule